// File: doc/BRIEF.md
# ADC Transfer Sequencer

This block moves results from two analog-to-digital converters into data memory under control of a short stored program. Software fills a 64-entry buffer of one-byte instructions, picks a boundary index at which each pass begins, a base data address and a 16-bit repeat limit, and then pulses start. The sequencer fetches one instruction at a time. An instruction names which converter results it wants. The sequencer waits until each named converter offers a result. It then writes the 16-bit results to memory through a simple write port and moves its data pointer forward.

A terminating instruction ends each pass and sends execution back to the boundary index. A flag inside that instruction chooses between two kinds of run. In a counted run, the program runs as many passes as the repeat limit asks and then stops with a one-cycle done pulse. In a continuous run, the program keeps running until software aborts it. Each converter uses a level ready signal with a one-cycle acknowledge. The converters, the bus fabric and the memory are outside this block.

Top module: `adc_dma_seq`

## Requirements
- R1: After reset, busy, done, mem_we and cnv_ack are all low, and the block sits idle.
- R2: A start pulse while idle captures the boundary index, the base address and the repeat limit, and raises busy. Later changes to those inputs, and start pulses while busy, have no effect on the running operation.
- R3: Instruction encoding: bit 4 selects converter 0, bit 5 selects converter 1, bit 6 marks end of pass, and bit 7 is the continuous flag. An instruction with bits 4, 5 and 6 all clear is a no-op. The converter bits of an end-of-pass instruction are ignored, so it causes no write.
- R4: No write for an instruction happens until every converter it selects shows ready high. Each converter whose result is taken gets a cnv_ack pulse of exactly one cycle.
- R5: Each result is written as one 16-bit word. When both converters are selected, the converter 0 word is written first, then the converter 1 word. The data address grows by 2 after every word, so it grows by 4 for a two-converter instruction.
- R6: After each instruction that is not end-of-pass, the instruction index advances by one, and it wraps from 63 to 0.
- R7: An end-of-pass instruction reloads the captured boundary index. With the continuous flag clear, a run makes exactly as many passes as the repeat limit, and a limit of 0 behaves like 1. After the last pass, busy falls and done is high for exactly one cycle, in the same cycle that busy falls.
- R8: With the continuous flag set, passes repeat without end. An abort pulse returns the block to idle from any state. The next cycle shows busy low, and no further writes and no done pulse follow.
- R9: The data address carries on across passes. It is loaded from the base address only when an operation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Instruction buffer write enable |
| prog_idx | input | 6 | Instruction buffer write index |
| prog_byte | input | 8 | Instruction byte to store |
| start | input | 1 | Start pulse (honoured only when idle) |
| abort | input | 1 | Abort pulse, returns to idle |
| bound_idx | input | 6 | Index at which each pass begins |
| base_addr | input | 16 | First data memory byte address |
| rpt_limit | input | 16 | Number of passes in a counted run |
| cnv0_rdy | input | 1 | Converter 0 result valid (level) |
| cnv0_data | input | 16 | Converter 0 result |
| cnv1_rdy | input | 1 | Converter 1 result valid (level) |
| cnv1_data | input | 16 | Converter 1 result |
| cnv_ack | output | 2 | One-cycle acknowledge per converter (bit 0 = converter 0) |
| mem_we | output | 1 | Data memory write strobe |
| mem_addr | output | 16 | Data memory byte address |
| mem_wdata | output | 16 | Data memory write word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when a counted run completes |

## Verification
The main program mixes single-converter, dual-converter and no-op instructions. It runs for several counted passes, which separates the write ordering, the address step of 2 against 4, and the address that carries on across pass boundaries. A second run holds one converter back much longer than the other. This shows that a write waits for every selected converter, and that converter 0 still comes first when converter 1 is ready earlier. Further programs start near index 63 to force the index to wrap. Another uses a repeat limit of 0 to separate "0 passes" from "one pass". A continuous program whose terminating byte also carries converter bits is stopped by abort, which shows that those bits cause no write and that no done pulse follows. A start pulse and a new boundary index applied mid-run must leave the expected write stream unchanged.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;
  // instruction bit positions (decoded by the sequencer)
  localparam int unsigned INS_W     = 8;
  localparam int unsigned BIT_SEL0  = 4;
  localparam int unsigned BIT_SEL1  = 5;
  localparam int unsigned BIT_EOP   = 6;
  localparam int unsigned BIT_CONT  = 7;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_EXEC  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_WR1   = 3'd4
  } seq_state_t;
endpackage

// File: rtl/instr_mem.sv
module instr_mem #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned W     = 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_val
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [W-1:0] store [DEPTH];

  // one write port, one registered read port: maps onto a simple dual-port RAM
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_val;
  end

  always_ff @(posedge clk) begin
    rd_val <= store[rd_idx];
  end
endmodule

// File: rtl/seq_core.sv
module seq_core
  import adc_dma_pkg::*;
#(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic [IDX_W-1:0]  bound_idx,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  rpt_limit,
  output logic [IDX_W-1:0]  ins_idx,
  input  logic [INS_W-1:0]  ins_val,
  input  logic              cnv0_rdy,
  input  logic [DATA_W-1:0] cnv0_data,
  input  logic              cnv1_rdy,
  input  logic [DATA_W-1:0] cnv1_data,
  output logic [1:0]        cnv_ack,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(DATA_W / 8);
  localparam logic [CNT_W-1:0]  ONE_PASS  = CNT_W'(1);

  seq_state_t        st;
  logic [IDX_W-1:0]  bnd_q;
  logic [ADDR_W-1:0] dptr;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        sel_q;
  logic [DATA_W-1:0] hold1;
  logic [1:0]        ins_sel;
  logic              all_rdy;

  assign ins_sel = {ins_val[BIT_SEL1], ins_val[BIT_SEL0]};
  assign all_rdy = (!sel_q[0] || cnv0_rdy) && (!sel_q[1] || cnv1_rdy);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bnd_q     <= '0;
      ins_idx   <= '0;
      dptr      <= '0;
      cnt       <= '0;
      sel_q     <= '0;
      hold1     <= '0;
      cnv_ack   <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      cnv_ack <= '0;
      done    <= 1'b0;
      if (abort) begin
        st   <= ST_IDLE;
        busy <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: begin
            if (start) begin
              bnd_q   <= bound_idx;
              ins_idx <= bound_idx;
              dptr    <= base_addr;
              cnt     <= rpt_limit;
              busy    <= 1'b1;
              st      <= ST_FETCH;
            end
          end
          ST_FETCH: st <= ST_EXEC;  // buffer read latency
          ST_EXEC: begin
            if (ins_val[BIT_EOP]) begin
              ins_idx <= bnd_q;
              if (ins_val[BIT_CONT]) begin
                st <= ST_FETCH;
              end else if (cnt <= ONE_PASS) begin
                cnt  <= '0;
                busy <= 1'b0;
                done <= 1'b1;
                st   <= ST_IDLE;
              end else begin
                cnt <= cnt - ONE_PASS;
                st  <= ST_FETCH;
              end
            end else if (ins_sel == 2'b00) begin
              ins_idx <= ins_idx + 1'b1;
              st      <= ST_FETCH;
            end else begin
              sel_q <= ins_sel;
              st    <= ST_WAIT;
            end
          end
          ST_WAIT: begin
            if (all_rdy) begin
              cnv_ack   <= sel_q;
              mem_we    <= 1'b1;
              mem_addr  <= dptr;
              mem_wdata <= sel_q[0] ? cnv0_data : cnv1_data;
              hold1     <= cnv1_data;
              dptr      <= dptr + WORD_STEP;
              if (sel_q == 2'b11) begin
                st <= ST_WR1;
              end else begin
                ins_idx <= ins_idx + 1'b1;
                st      <= ST_FETCH;
              end
            end
          end
          ST_WR1: begin
            mem_we    <= 1'b1;
            mem_addr  <= dptr;
            mem_wdata <= hold1;
            dptr      <= dptr + WORD_STEP;
            ins_idx   <= ins_idx + 1'b1;
            st        <= ST_FETCH;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + WORD_STEP));
  // R4
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst) (|cnv_ack) |=> (cnv_ack == 2'b00));
  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(start));
  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst) abort |=> (!busy && !mem_we && !done));
  // R5
  write_busy_chk: assert property (@(posedge clk) disable iff (rst) mem_we |-> busy);
endmodule

// File: rtl/adc_dma_seq.sv
module adc_dma_seq
  import adc_dma_pkg::*;
#(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_we,
  input  logic [IDX_W-1:0]  prog_idx,
  input  logic [INS_W-1:0]  prog_byte,
  input  logic              start,
  input  logic              abort,
  input  logic [IDX_W-1:0]  bound_idx,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  rpt_limit,
  input  logic              cnv0_rdy,
  input  logic [DATA_W-1:0] cnv0_data,
  input  logic              cnv1_rdy,
  input  logic [DATA_W-1:0] cnv1_data,
  output logic [1:0]        cnv_ack,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done
);
  logic [IDX_W-1:0] rd_idx;
  logic [INS_W-1:0] rd_val;

  instr_mem #(.IDX_W(IDX_W), .W(INS_W)) u_buf (
    .clk    (clk),
    .wr_en  (prog_we),
    .wr_idx (prog_idx),
    .wr_val (prog_byte),
    .rd_idx (rd_idx),
    .rd_val (rd_val)
  );

  seq_core #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .abort     (abort),
    .bound_idx (bound_idx),
    .base_addr (base_addr),
    .rpt_limit (rpt_limit),
    .ins_idx   (rd_idx),
    .ins_val   (rd_val),
    .cnv0_rdy  (cnv0_rdy),
    .cnv0_data (cnv0_data),
    .cnv1_rdy  (cnv1_rdy),
    .cnv1_data (cnv1_data),
    .cnv_ack   (cnv_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done)
  );
endmodule

// File: tb/tb_adc_dma_seq.sv
`timescale 1ns/1ps
module tb_adc_dma_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_we = 1'b0;
  logic [5:0]  prog_idx = '0;
  logic [7:0]  prog_byte = '0;
  logic        start = 1'b0;
  logic        abort = 1'b0;
  logic [5:0]  bound_idx = '0;
  logic [15:0] base_addr = '0;
  logic [15:0] rpt_limit = '0;
  logic        cnv0_rdy, cnv1_rdy;
  logic [15:0] cnv0_data, cnv1_data;
  logic [1:0]  cnv_ack;
  logic        mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic        busy, done;

  always #10 clk = ~clk;  // 50 MHz

  adc_dma_seq dut (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_idx(prog_idx), .prog_byte(prog_byte),
    .start(start), .abort(abort), .bound_idx(bound_idx), .base_addr(base_addr),
    .rpt_limit(rpt_limit), .cnv0_rdy(cnv0_rdy), .cnv0_data(cnv0_data),
    .cnv1_rdy(cnv1_rdy), .cnv1_data(cnv1_data), .cnv_ack(cnv_ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .done(done)
  );

  int errors = 0;
  int checks = 0;
  int done_cnt = 0;
  int wr_cnt = 0;
  logic [7:0] prog [64];
  logic [31:0] exp_q [$];

  // converter models: level ready, new sample after each acknowledge
  logic        mdl_clr = 1'b0;
  int          gap0 = 0, gap1 = 0;
  int          wait0 = 0, wait1 = 0;
  logic [15:0] n0 = '0, n1 = '0;
  assign cnv0_rdy  = (wait0 == 0);
  assign cnv1_rdy  = (wait1 == 0);
  assign cnv0_data = 16'hA000 + n0;
  assign cnv1_data = 16'hB000 + n1;

  always @(negedge clk) begin
    if (mdl_clr) begin
      n0 <= '0; n1 <= '0; wait0 <= gap0; wait1 <= gap1;
    end else begin
      if (cnv_ack[0]) begin n0 <= n0 + 1'b1; wait0 <= gap0; end
      else if (wait0 > 0) wait0 <= wait0 - 1;
      if (cnv_ack[1]) begin n1 <= n1 + 1'b1; wait1 <= gap1; end
      else if (wait1 > 0) wait1 <= wait1 - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every write (R5, R9)
  always @(negedge clk) begin
    if (!rst && done) done_cnt++;
    if (!rst && mem_we) begin
      wr_cnt++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected write", {mem_addr, mem_wdata}, 32'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R5", "write addr/data", {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic put(input int idx, input logic [7:0] v);
    @(negedge clk);
    prog_we = 1'b1; prog_idx = 6'(idx); prog_byte = v; prog[idx] = v;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) put(i, 8'h00);
  endtask

  // independent expected model of one operation (R3, R5, R6, R9)
  task automatic build_exp(input int bnd, input logic [15:0] base, input int passes);
    logic [15:0] a;
    logic [15:0] e0, e1;
    a = base; e0 = '0; e1 = '0;
    for (int p = 0; p < passes; p++) begin
      int idx;
      idx = bnd;
      for (int s = 0; s < 64; s++) begin
        logic [7:0] ins;
        ins = prog[idx];
        if (ins[6]) break;
        if (ins[4]) begin exp_q.push_back({a, 16'hA000 + e0}); e0++; a = a + 16'd2; end
        if (ins[5]) begin exp_q.push_back({a, 16'hB000 + e1}); e1++; a = a + 16'd2; end
        idx = (idx + 1) % 64;
      end
    end
  endtask

  task automatic begin_op(input int bnd, input logic [15:0] base, input logic [15:0] lim);
    @(negedge clk);
    mdl_clr = 1'b1;
    @(negedge clk);
    mdl_clr = 1'b0;
    bound_idx = 6'(bnd); base_addr = base; rpt_limit = lim;
    done_cnt = 0; wr_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic end_op(input string req);
    int t;
    t = 0;
    while (done_cnt == 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, req, "one done pulse", 32'(done_cnt), 32'd1);
    chk(!busy, req, "busy low after run", {31'd0, busy}, 32'd0);
    chk(exp_q.size() == 0, req, "all expected writes seen", 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_we && cnv_ack == 2'b00, "R1", "idle after reset",
        {28'd0, busy, done, mem_we, |cnv_ack}, 32'd0);

    // main program, three counted passes, mid-run start and boundary change (R2, R3, R7, R9)
    clear_prog();
    put(2, 8'h10); put(3, 8'h30); put(4, 8'h00); put(5, 8'h20); put(6, 8'h40);
    put(10, 8'h30); put(11, 8'h40);
    build_exp(2, 16'h0100, 3);
    begin_op(2, 16'h0100, 16'd3);
    chk(busy, "R2", "busy after start", {31'd0, busy}, 32'd1);
    repeat (10) @(negedge clk);
    bound_idx = 6'd10; base_addr = 16'h7000; rpt_limit = 16'd9;
    start = 1'b1; @(negedge clk); start = 1'b0;
    end_op("R7");
    chk(wr_cnt == 12, "R9", "write count three passes", 32'(wr_cnt), 32'd12);

    // slow converter 0: write must wait, order must hold (R4, R5)
    gap0 = 60; gap1 = 1;
    put(2, 8'h30); put(3, 8'h40);
    build_exp(2, 16'h0200, 2);
    begin_op(2, 16'h0200, 16'd2);
    repeat (40) @(negedge clk);
    chk(wr_cnt == 0, "R4", "no write before converter 0 ready", 32'(wr_cnt), 32'd0);
    end_op("R4");
    gap0 = 0; gap1 = 0;

    // limit 0 behaves as one pass (R7)
    put(2, 8'h10); put(3, 8'h40);
    build_exp(2, 16'h0300, 1);
    begin_op(2, 16'h0300, 16'd0);
    end_op("R7");
    chk(wr_cnt == 1, "R7", "limit zero one pass", 32'(wr_cnt), 32'd1);

    // index wrap 63 -> 0 (R6)
    clear_prog();
    put(62, 8'h10); put(63, 8'h20); put(0, 8'h30); put(1, 8'h40);
    build_exp(62, 16'h0400, 2);
    begin_op(62, 16'h0400, 16'd2);
    end_op("R6");
    chk(wr_cnt == 8, "R6", "writes across wrap", 32'(wr_cnt), 32'd8);

    // continuous run, terminator carries converter bits, then abort (R3, R8)
    clear_prog();
    put(0, 8'h10); put(1, 8'hF0);
    build_exp(0, 16'h0500, 6);
    begin_op(0, 16'h0500, 16'd1);
    begin
      int t;
      t = 0;
      while (exp_q.size() != 0 && t < 5000) begin @(negedge clk); t++; end
    end
    chk(busy, "R8", "still busy past limit", {31'd0, busy}, 32'd1);
    chk(wr_cnt == 6, "R3", "terminator writes nothing", 32'(wr_cnt), 32'd6);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk(!busy, "R8", "busy low after abort", {31'd0, busy}, 32'd0);
    repeat (30) @(negedge clk);
    chk(wr_cnt == 6 && done_cnt == 0, "R8", "no writes or done after abort",
        {wr_cnt[15:0], done_cnt[15:0]}, {16'd6, 16'd0});

    // restart after abort (R2)
    put(1, 8'h40);
    build_exp(0, 16'h0600, 2);
    begin_op(0, 16'h0600, 16'd2);
    end_op("R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule